// File: doc/BRIEF.md
# Branch Squash and Fetch Steering Controller

This block steers instruction fetch and squashes wrong-path work for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle an upstream source may offer one instruction token. The token carries an ID, a branch flag, the branch outcome and the branch target. The controller stamps the current fetch address on the token and moves it down a five-entry token pipeline. A taken branch acts when it reaches the resolving stage. That stage is set by a parameter, counted from 1 at fetch, and defaults to the memory stage. When it acts, fetch is redirected to the target in that same cycle. The younger tokens that must not commit are turned into bubbles.

Two branch policies can be selected. Under predict-not-taken, fetch continues sequentially and every younger token is squashed when a branch turns out taken. Under the one-slot delayed-branch policy, the token right behind the branch always completes and only the tokens behind it are squashed. Writeback is the only stage that updates architectural state, so a squash always takes effect before any write. Tokens leave on a retire stream, which has no ready input because the pipeline never stalls. A low offer valid simply inserts a bubble and the fetch address holds.

Top module: `bhz_steer`

## Requirements
- R1: While `rst` is high and on the cycle after its release, `fetch_pc` is 0, `stage_valid` is all zero, `retire_valid` is 0 and `policy_sts` is 0.
- R2: With no redirect, an accepted token (`in_valid`=1) advances the next `fetch_pc` by 4. A bubble leaves it unchanged.
- R3: A live taken branch in the resolving stage (stage index RES_STAGE, 1-based, default 4) drives `fetch_pc` to its target in that same cycle. Fetch then continues sequentially from the target.
- R4: Under `policy_sel`=0 (predict not taken), a taken branch kills all RES_STAGE-1 valid younger stages. `kill` bit j marks stage j, with bit 0 = fetch and bit 4 = writeback.
- R5: Under `policy_sel`=1 (delayed branch), the token directly behind the branch is not killed and retires. Only the RES_STAGE-2 tokens behind it are killed.
- R6: A branch that is not taken causes no kill and no redirect.
- R7: A killed token becomes a bubble. It never produces `retire_valid` (the writeback write enable).
- R8: A branch token sitting in a killed slot never redirects fetch and never kills anything.
- R9: `policy_sts` shows `policy_sel` as registered one cycle earlier. The registered value selects the squash policy.
- R10: Every surviving token retires in program order, 5 cycles after it was offered, with its ID and the fetch address it was stamped with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 1 | 0 = predict not taken, 1 = one-slot delayed branch |
| in_valid | input | 1 | A token is offered this cycle |
| in_id | input | ID_W | Token identifier |
| in_is_br | input | 1 | Token is a branch |
| in_taken | input | 1 | Branch outcome |
| in_target | input | PC_W | Branch target address |
| fetch_pc | output | PC_W | Address stamped on the token offered this cycle |
| stage_valid | output | NSTG | Valid flag per stage, bit 0 = fetch |
| kill | output | NSTG | Stages squashed this cycle |
| policy_sts | output | 1 | Active squash policy |
| retire_valid | output | 1 | Token in writeback commits (write enable) |
| retire_id | output | ID_W | ID of the retiring token |
| retire_pc | output | PC_W | Address of the retiring token |

## Verification
The hardest situations to reach from the ports are a second branch that lands inside the squash window and a branch in the delay slot. In those cases the outcome depends on whether the first branch killed the second before the second reached resolution. The bench runs a sweep over both policies and both outcomes of a first branch. It places a second branch at every distance from one to five slots behind the first, with and without bubbles in the stream. For each case it predicts from slot arithmetic the fetch address per cycle, the kill vector and every retirement.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  typedef enum logic {
    POL_NOT_TAKEN  = 1'b0,
    POL_DELAY_SLOT = 1'b1
  } br_policy_e;

  localparam int unsigned N_STAGES   = 5;
  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/bhz_pc_gen.sv
module bhz_pc_gen #(
  parameter int unsigned PC_W = 16,
  parameter int unsigned STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic            res_hit,
  input  logic [PC_W-1:0] res_tgt,
  output logic [PC_W-1:0] fetch_pc
);
  logic [PC_W-1:0] pc_q;

  // redirect is combinational so the target is fetched in the resolve cycle
  assign fetch_pc = res_hit ? res_tgt : pc_q;

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= '0;
    else if (acc) pc_q <= fetch_pc + PC_W'(STEP);
    else          pc_q <= fetch_pc;
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!res_hit && acc) |=> (pc_q == $past(pc_q) + PC_W'(STEP))); // R2
  AST_REDIRECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_hit && !acc) |=> (pc_q == $past(res_tgt))); // R3
endmodule

// File: rtl/bhz_token_pipe.sv
module bhz_token_pipe #(
  parameter int unsigned NSTG      = 5,
  parameter int unsigned RES_STAGE = 4,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned ID_W      = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic [ID_W-1:0] in_id,
  input  logic [PC_W-1:0] in_pc,
  input  logic            in_br,
  input  logic            in_tk,
  input  logic [PC_W-1:0] in_tgt,
  input  logic [NSTG-1:0] kill,
  output logic [NSTG-1:0] vld,
  output logic            res_hit,
  output logic [PC_W-1:0] res_tgt,
  output logic            ret_vld,
  output logic [ID_W-1:0] ret_id,
  output logic [PC_W-1:0] ret_pc
);
  localparam int unsigned R = RES_STAGE - 1;  // 0-based resolving stage

  logic [ID_W-1:0] id_q  [NSTG];
  logic [PC_W-1:0] pc_q  [NSTG];
  logic [R:0]      br_q, tk_q;
  logic [PC_W-1:0] tgt_q [R+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= acc;
      for (int j = 1; j < NSTG; j++) vld[j] <= vld[j-1] & ~kill[j-1];
    end
  end

  always_ff @(posedge clk) begin
    id_q[0]  <= in_id;
    pc_q[0]  <= in_pc;
    tgt_q[0] <= in_tgt;
    br_q     <= {br_q[R-1:0], in_br};
    tk_q     <= {tk_q[R-1:0], in_tk};
    for (int j = 1; j < NSTG; j++) begin
      id_q[j] <= id_q[j-1];
      pc_q[j] <= pc_q[j-1];
    end
    for (int j = 1; j <= R; j++) tgt_q[j] <= tgt_q[j-1];
  end

  assign res_hit = vld[R] & br_q[R] & tk_q[R];
  assign res_tgt = tgt_q[R];
  assign ret_vld = vld[NSTG-1] & ~kill[NSTG-1];
  assign ret_id  = id_q[NSTG-1];
  assign ret_pc  = pc_q[NSTG-1];

  for (genvar j = 0; j < NSTG - 1; j++) begin : g_kchk
    AST_KILL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
      kill[j] |=> !vld[j+1]); // R7
  end
endmodule

// File: rtl/bhz_squash_ctl.sv
module bhz_squash_ctl
  import bhz_pkg::*;
#(
  parameter int unsigned NSTG      = 5,
  parameter int unsigned RES_STAGE = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policy_sel,
  input  logic                 res_hit,
  input  logic [RES_STAGE-2:0] younger_vld,
  output br_policy_e           policy_q,
  output logic [NSTG-1:0]      kill
);
  localparam int unsigned R = RES_STAGE - 1;

  always_ff @(posedge clk) begin
    if (rst) policy_q <= POL_NOT_TAKEN;
    else     policy_q <= br_policy_e'(policy_sel);
  end

  for (genvar j = 0; j < NSTG; j++) begin : g_kill
    if (j < R - 1) begin : g_always
      assign kill[j] = res_hit & younger_vld[j];
    end else if (j == R - 1) begin : g_slot
      // stage right behind the resolver is the delay slot
      assign kill[j] = res_hit & younger_vld[j] & (policy_q == POL_NOT_TAKEN);
    end else begin : g_never
      assign kill[j] = 1'b0;
    end
  end
endmodule

// File: rtl/bhz_steer.sv
module bhz_steer
  import bhz_pkg::*;
#(
  parameter int unsigned NSTG      = N_STAGES,
  parameter int unsigned RES_STAGE = 4,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned ID_W      = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            policy_sel,
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_id,
  input  logic            in_is_br,
  input  logic            in_taken,
  input  logic [PC_W-1:0] in_target,
  output logic [PC_W-1:0] fetch_pc,
  output logic [NSTG-1:0] stage_valid,
  output logic [NSTG-1:0] kill,
  output logic            policy_sts,
  output logic            retire_valid,
  output logic [ID_W-1:0] retire_id,
  output logic [PC_W-1:0] retire_pc
);
  localparam int unsigned R = RES_STAGE - 1;

  logic            res_hit;
  logic [PC_W-1:0] res_tgt;
  br_policy_e      policy_q;

  bhz_pc_gen #(.PC_W(PC_W), .STEP(INSN_BYTES)) i_pc_gen (
    .clk(clk), .rst(rst), .acc(in_valid), .res_hit(res_hit),
    .res_tgt(res_tgt), .fetch_pc(fetch_pc)
  );

  bhz_token_pipe #(.NSTG(NSTG), .RES_STAGE(RES_STAGE), .PC_W(PC_W), .ID_W(ID_W)) i_pipe (
    .clk(clk), .rst(rst), .acc(in_valid), .in_id(in_id), .in_pc(fetch_pc),
    .in_br(in_is_br), .in_tk(in_taken), .in_tgt(in_target), .kill(kill),
    .vld(stage_valid), .res_hit(res_hit), .res_tgt(res_tgt),
    .ret_vld(retire_valid), .ret_id(retire_id), .ret_pc(retire_pc)
  );

  bhz_squash_ctl #(.NSTG(NSTG), .RES_STAGE(RES_STAGE)) i_squash (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .res_hit(res_hit),
    .younger_vld(stage_valid[R-1:0]), .policy_q(policy_q), .kill(kill)
  );

  assign policy_sts = policy_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (stage_valid == '0 && !retire_valid && fetch_pc == '0)); // R1
  AST_DELAY_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (policy_q == POL_DELAY_SLOT && res_hit && stage_valid[R-1]) |=> stage_valid[R]); // R5
  AST_SHADOW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (policy_q == POL_NOT_TAKEN && res_hit) |=> !res_hit); // R8
endmodule

// File: tb/test_bhz_steer.sv
module test_bhz_steer;
  localparam int PC_W = 16, ID_W = 8, NSTG = 5, RES = 4, D = RES;
  localparam int NC = 30, NSL = 20;

  logic clk = 1'b0, rst = 1'b1, policy_sel = 1'b0, in_valid = 1'b0;
  logic in_is_br = 1'b0, in_taken = 1'b0;
  logic [ID_W-1:0] in_id = '0;
  logic [PC_W-1:0] in_target = '0;
  logic [PC_W-1:0] fetch_pc, retire_pc;
  logic [NSTG-1:0] stage_valid, kill;
  logic policy_sts, retire_valid;
  logic [ID_W-1:0] retire_id;

  bhz_steer i_bhz_steer (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .in_valid(in_valid),
    .in_id(in_id), .in_is_br(in_is_br), .in_taken(in_taken), .in_target(in_target),
    .fetch_pc(fetch_pc), .stage_valid(stage_valid), .kill(kill),
    .policy_sts(policy_sts), .retire_valid(retire_valid),
    .retire_id(retire_id), .retire_pc(retire_pc)
  );

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;

  bit s_v[NC], s_br[NC], s_tk[NC], alive[NC], killed[NC], redir[NC+D];
  logic [PC_W-1:0] s_tg[NC], spc[NC], fpc[NC], rtgt[NC+D];
  logic [NSTG-1:0] expk[NC+D];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: slot c offered in cycle c resolves in cycle c+D, retires in c+5
  task automatic build(input int m, input bit t1, input bit t2, input int d, input int g);
    logic [PC_W-1:0] cur;
    for (int c = 0; c < NC + D; c++) begin
      redir[c] = 1'b0; rtgt[c] = '0; expk[c] = '0;
    end
    for (int c = 0; c < NC; c++) begin
      s_v[c] = (c < NSL) && !(g == 1 && (c == 5 || c == 10));
      s_br[c] = 1'b0; s_tk[c] = 1'b0; s_tg[c] = '0; killed[c] = 1'b0;
    end
    s_br[3] = 1'b1;     s_tk[3] = t1;     s_tg[3] = 16'h0100;
    s_br[3+d] = 1'b1;   s_tk[3+d] = t2;   s_tg[3+d] = 16'h0200;
    s_br[14] = 1'b1;    s_tk[14] = 1'b1;  s_tg[14] = 16'h0040;
    cur = '0;
    for (int c = 0; c < NC; c++) begin
      fpc[c] = redir[c] ? rtgt[c] : cur;
      if (s_v[c]) begin spc[c] = fpc[c]; cur = fpc[c] + 16'd4; end
      else cur = fpc[c];
      alive[c] = s_v[c] && !killed[c];
      if (alive[c] && s_br[c] && s_tk[c]) begin
        redir[c+D] = 1'b1; rtgt[c+D] = s_tg[c];
        for (int k = c + (m ? 2 : 1); k <= c + D - 1; k++)
          if (k < NC && s_v[k] && !killed[k]) begin
            killed[k] = 1'b1;
            expk[c+D][c+D-1-k] = 1'b1;
          end
      end
    end
  endtask

  task automatic run_one(input int m, input bit t1, input bit t2, input int d, input int g);
    build(m, t1, t2, d, g);
    rst = 1'b1; policy_sel = m[0]; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(fetch_pc == '0, "R1", "fetch_pc in reset", fetch_pc, 0);
    chk(stage_valid == '0, "R1", "stage_valid in reset", stage_valid, 0);
    chk(!retire_valid, "R1", "retire_valid in reset", retire_valid, 0);
    chk(!policy_sts, "R1", "policy_sts in reset", policy_sts, 0);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) begin
      chk(fetch_pc == fpc[c], redir[c] ? "R3" : "R2", "fetch_pc", fetch_pc, fpc[c]);
      chk(kill == expk[c], (expk[c] == '0) ? "R6" : (m ? "R5" : "R4"), "kill", kill, expk[c]);
      if (c >= 1) chk(policy_sts == m[0], "R9", "policy_sts", policy_sts, m);
      if (c >= 5) begin
        chk(retire_valid == alive[c-5],
            (killed[c-5] && s_br[c-5]) ? "R8" : (killed[c-5] ? "R7" : "R10"),
            "retire_valid", retire_valid, alive[c-5]);
        if (alive[c-5] && retire_valid) begin
          chk(retire_id == ID_W'(c - 5 + 16), "R10", "retire_id", retire_id, c - 5 + 16);
          chk(retire_pc == spc[c-5], "R10", "retire_pc", retire_pc, spc[c-5]);
        end
      end
      in_valid = s_v[c]; in_id = ID_W'(c + 16); in_is_br = s_br[c];
      in_taken = s_tk[c]; in_target = s_tg[c];
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int t1 = 0; t1 < 2; t1++)
        for (int t2 = 0; t2 < 2; t2++)
          for (int d = 1; d <= 5; d++)
            for (int g = 0; g < 2; g++)
              run_one(m, t1[0], t2[0], d, g);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule